// File: doc/BRIEF.md
# SMM RAM Access Controller

This block holds the 8-bit control register that decides whether accesses which fall inside the system-management RAM region may reach the DRAM behind it. It also contains the decision logic that applies that register to each access. Software writes the register through a simple write strobe and data byte. The current register value is always visible on a read bus.

For each access, the block receives three inputs: a flag saying the address is inside the SMM region, a flag saying the processor is in system-management mode, and a flag telling a code fetch from a data reference. One clock later the block returns a grant. A global enable gates every rule. An "open" bit makes the region visible outside SMM mode. A "close" bit hides the region from data references while code fetches still pass. A self-setting lock bit freezes the open and enable fields until reset.

Top module: `smm_ram_guard`

## Requirements
- R1: After a synchronous reset the register reads 02h and `grant` is 0.
- R2: Bit 7 always reads 0 and bits 2:0 always read 010b; writes to these bits are ignored.
- R3: Bit 5 (close) takes the written value on every write, locked or not.
- R4: Bit 4 (lock) is set by writing 1 to it and then stays 1 until reset; writing 0 to it has no effect.
- R5: While the lock is 1, bit 6 (open) and bit 3 (global enable) ignore writes.
- R6: A write that sets the lock while the register is unlocked stores bit 6 as 0, whatever value is written there.
- R7: While bit 3 (global enable) is 0, `grant` is 0.
- R8: While `in_region` is 0, `grant` is 0.
- R9: With global enable 1, `smm_active` 1 and `in_region` 1, `grant` is 1 unless close is 1 and `ref_is_code` is 0 (a data reference).
- R10: With global enable 1, `smm_active` 0 and `in_region` 1, `grant` is 1 only when open is 1, lock is 0, and not (close is 1 with a data reference). Close wins over open for data references.
- R11: `grant` is registered. It reflects the access inputs and the register value present at the previous rising clock edge, so a write lands in the register at one edge and affects `grant` from the next edge onwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register value |
| smm_active | input | 1 | Processor is in system-management mode |
| ref_is_code | input | 1 | 1 = code fetch, 0 = data reference |
| in_region | input | 1 | Access address lies in the SMM region |
| grant | output | 1 | Access may reach SMM DRAM (one cycle after the inputs) |

## Verification
The assertions assume that the access inputs and the write port are sampled only at rising edges. They also assume that each grant check compares the output against the register and inputs of the edge before it. No other assumption is made about the inputs, so any mix of strobes and flags is legal. The bench changes every input at the falling edge, holds it through one rising edge, and checks at the next falling edge. It walks all 256 write bytes from reset and, for each one, all eight access-flag combinations and a second, complementary write. This covers locked, unlocked, open-with-close and disabled states without leaving the assumed timing.

// File: rtl/smm_guard_pkg.sv
package smm_guard_pkg;
  localparam int REG_W     = 8;
  localparam int SEG_W     = 3;
  localparam int B_RSVD    = 7;
  localparam int B_OPEN    = 6;
  localparam int B_CLOSE   = 5;
  localparam int B_LOCK    = 4;
  localparam int B_GEN     = 3;
  localparam logic [SEG_W-1:0] SEG_FIXED = 3'b010;

  typedef struct packed {
    logic open;
    logic close;
    logic lock;
    logic gen;
  } smm_ctl_t;
endpackage

// File: rtl/smm_ctl_reg.sv
module smm_ctl_reg
  import smm_guard_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output smm_ctl_t     ctl,
  output logic [W-1:0] rd_data
);
  smm_ctl_t cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (wr_en) begin
      cur.close <= wr_data[B_CLOSE];
      if (!cur.lock) begin
        cur.gen  <= wr_data[B_GEN];
        cur.open <= wr_data[B_LOCK] ? 1'b0 : wr_data[B_OPEN];
        cur.lock <= wr_data[B_LOCK];
      end
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[B_RSVD]   = 1'b0;
    rd_data[B_OPEN]   = cur.open;
    rd_data[B_CLOSE]  = cur.close;
    rd_data[B_LOCK]   = cur.lock;
    rd_data[B_GEN]    = cur.gen;
    rd_data[SEG_W-1:0] = SEG_FIXED;
  end

  assign ctl = cur;
endmodule

// File: rtl/smm_access_decide.sv
module smm_access_decide
  import smm_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  smm_ctl_t ctl,
  input  logic     smm_active,
  input  logic     ref_is_code,
  input  logic     in_region,
  output logic     grant
);
  logic eff_open, data_blocked, allow;

  always_comb begin
    eff_open     = ctl.open & ~ctl.lock;
    data_blocked = ctl.close & ~ref_is_code;
    allow        = in_region & ctl.gen & (smm_active | eff_open) & ~data_blocked;
  end

  always_ff @(posedge clk) begin
    if (rst) grant <= 1'b0;
    else     grant <= allow;
  end
endmodule

// File: rtl/smm_ram_guard.sv
module smm_ram_guard
  import smm_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             smm_active,
  input  logic             ref_is_code,
  input  logic             in_region,
  output logic             grant
);
  smm_ctl_t ctl;

  smm_ctl_reg #(.W(REG_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctl(ctl), .rd_data(rd_data)
  );

  smm_access_decide u_dec (
    .clk(clk), .rst(rst), .ctl(ctl), .smm_active(smm_active),
    .ref_is_code(ref_is_code), .in_region(in_region), .grant(grant)
  );
endmodule

// File: rtl/smm_ram_guard_chk.sv
module smm_ram_guard_chk
  import smm_guard_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] rd_data,
  input logic             smm_active,
  input logic             ref_is_code,
  input logic             in_region,
  input logic             grant
);
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_data[B_RSVD] == 1'b0) && (rd_data[SEG_W-1:0] == SEG_FIXED));

  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    rd_data[B_LOCK] |=> rd_data[B_LOCK]);

  a_r5_lock_freeze: assert property (@(posedge clk) disable iff (rst)
    rd_data[B_LOCK] |=> ($stable(rd_data[B_OPEN]) && $stable(rd_data[B_GEN])));

  a_r7_gen_off: assert property (@(posedge clk) disable iff (rst)
    !rd_data[B_GEN] |=> !grant);

  a_r8_out_region: assert property (@(posedge clk) disable iff (rst)
    !in_region |=> !grant);

  a_r9_close_data: assert property (@(posedge clk) disable iff (rst)
    (rd_data[B_CLOSE] && !ref_is_code) |=> !grant);

  a_r10_locked_outside: assert property (@(posedge clk) disable iff (rst)
    (rd_data[B_LOCK] && !smm_active) |=> !grant);
endmodule

bind smm_ram_guard smm_ram_guard_chk u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .smm_active(smm_active),
  .ref_is_code(ref_is_code), .in_region(in_region), .grant(grant)
);

// File: tb/sim_smm_ram_guard.sv
`timescale 1ns/1ps
module sim_smm_ram_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       smm_active = 1'b0;
  logic       ref_is_code = 1'b0;
  logic       in_region = 1'b0;
  logic       grant;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  smm_ram_guard u0 (.*);

  // Register model: open bit6, close bit5, lock bit4, enable bit3, bits2:0 = 010b
  function automatic logic [7:0] mdl_write(input logic [7:0] cur, input logic [7:0] w);
    logic [7:0] n;
    n = cur;
    n[5] = w[5];
    if (!cur[4]) begin
      n[3] = w[3];
      n[4] = w[4];
      n[6] = w[4] ? 1'b0 : w[6];
    end
    n[7] = 1'b0;
    n[2:0] = 3'b010;
    return n;
  endfunction

  function automatic logic mdl_grant(input logic [7:0] r, input logic smm, input logic code,
                                     input logic inr);
    if (!inr || !r[3]) return 1'b0;
    if (r[5] && !code) return 1'b0;
    if (smm) return 1'b1;
    return r[6] && !r[4];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    logic [7:0] m;
    do_reset();
    chk("R1 reset value", rd_data, 8'h02);
    chk("R1 reset grant", {7'd0, grant}, 8'h00);
    for (int w = 0; w < 256; w++) begin
      do_reset();
      m = mdl_write(8'h02, w[7:0]);
      do_write(w[7:0]);
      chk("R2 R3 R4 R6 write readback", rd_data, m);
      for (int a = 0; a < 8; a++) begin
        @(negedge clk);
        smm_active = a[0]; ref_is_code = a[1]; in_region = a[2];
        @(negedge clk);
        chk("R7 R8 R9 R10 R11 grant", {7'd0, grant},
            {7'd0, mdl_grant(m, a[0], a[1], a[2])});
      end
      m = mdl_write(m, ~w[7:0]);
      do_write(~w[7:0]);
      chk("R4 R5 R3 second write", rd_data, m);
      @(negedge clk);
      smm_active = 1'b0; ref_is_code = 1'b1; in_region = 1'b1;
      @(negedge clk);
      chk("R10 R11 grant after rewrite", {7'd0, grant}, {7'd0, mdl_grant(m, 1'b0, 1'b1, 1'b1)});
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule